// File: doc/BRIEF.md
# Erased Sector Zero-Bit Checker

When the BCH decoder gives up on a sector because it reports more flipped bits than it can repair, the failure may only be a freshly erased sector. Erased flash reads as all ones, and the check code stored for an all-ones sector does not match. This block settles which case applies. After an accepted start it takes the sector as a byte stream: the data bytes first, then the stored check bytes. It counts the zero bits in each region with a counter that saturates, and then gives a verdict.

If the two regions together hold no more zero bits than the decoder could have corrected, the sector is declared erased. The number of zero bits in the data region is reported as the count of corrected bits. When that count is not zero, the block emits a burst of all-ones bytes, one per data byte position, so that the surrounding logic can overwrite its buffer. In every other case the sector is flagged uncorrectable. The block holds no page memory and does not decode.

Top module: `erased_sector_check`

## Requirements
- R1: A start pulse is accepted only when `err_count` is greater than 8. A start with `err_count` of 8 or less, and any byte streamed while no check is running, changes no output.
- R2: The zero bits of a byte are the ones in its bitwise complement. The first 512 bytes accepted after a start form the data region and the next 13 form the check region. A cycle with `in_valid` low contributes nothing.
- R3: Each region's zero count is 4 bits wide. Once the count would exceed 8 it holds at 9, meaning "more than 8", until the next accepted start.
- R4: An accepted start clears both counts, `done`, `erased`, `uncorrectable` and `data_zeros`, and restarts the stream at data byte 0. A byte presented with `in_valid` in the start cycle is counted as data byte 0. A start in the middle of a stream discards everything counted so far.
- R5: `done` is high for exactly one cycle: the cycle after the clock edge that accepts the last check byte. `erased`, `uncorrectable` and `data_zeros` keep their values from then until the next accepted start.
- R6: `erased` is 1 when the data count plus the check count is at most 8. Otherwise `uncorrectable` is 1. Exactly one of the two is set with `done`, and `data_zeros` equals the saturated data-region count.
- R7: When the verdict is erased and `data_zeros` is non-zero, `out_valid` is high for 512 consecutive cycles starting in the `done` cycle. During the burst `out_byte` is 0xFF and `out_idx` counts 0 to 511. For any other verdict `out_valid` stays low.
- R8: An accepted start during a burst ends it, and `out_valid` is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a sector check |
| err_count | input | 4 | Error count reported by the decoder, sampled with `start` |
| in_valid | input | 1 | `in_byte` holds a sector byte this cycle |
| in_byte | input | 8 | Sector byte stream: data region, then check region |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| erased | output | 1 | Verdict: sector judged erased |
| uncorrectable | output | 1 | Verdict: sector cannot be recovered |
| data_zeros | output | 4 | Saturated zero count of the data region (9 means more than 8) |
| out_valid | output | 1 | Fill burst byte valid |
| out_idx | output | 9 | Data byte position of the fill byte |
| out_byte | output | 8 | Fill byte, 0xFF during the burst |

## Verification
Two functions can fall in the same cycle. An accepted start can coincide with a valid byte, so clearing the counters and counting the first data byte happen on one edge. A start can also land while a fill burst is running, so the restart and the burst termination collide. The bench provokes the first by driving `in_valid` with a byte that carries one zero bit in the start cycle of a restart, and expects that bit in `data_zeros`. It provokes the second by pulsing start partway through a burst, then checks that `out_valid` and the verdict flags are low one cycle later and that the new sector is then judged on its own bytes. Randomised sectors with sparse zero bits and random idle gaps, plus directed sums at 8 and 9, fix the boundary between the two verdicts.

// File: rtl/esc_pkg.sv
// Package: shared types and helpers for the erased sector checker.
// Assumes byte-wide streams; the zero count of a byte never exceeds 8.
package esc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_ECC  = 2'd2,
        PH_FILL = 2'd3
    } phase_t;

    // Number of zero bits in one byte (ones of its complement).
    function automatic logic [3:0] zeros_in_byte(input logic [7:0] b);
        logic [3:0] n;
        n = 4'd0;
        for (int i = 0; i < 8; i++) begin
            n = n + {3'd0, ~b[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/esc_zero_tally.sv
// Module: saturating zero-bit tally for one region of the sector.
// Adds the zero bits of each accepted byte. Once the sum passes LIMIT the
// count sticks at LIMIT+1. A clear coinciding with an add yields the
// byte's own count. Assumes LIMIT >= 7 so a byte count fits in CW bits.
module esc_zero_tally #(
    parameter int LIMIT = 8,
    parameter int CW    = $clog2(LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add_en,
    input  logic [7:0]    byte_in,
    output logic [CW-1:0] cnt_nxt
);
    import esc_pkg::*;

    localparam int SAT = LIMIT + 1;
    localparam int SW  = $clog2(LIMIT + 10);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;
    logic [SW-1:0] sum;

    // Next count: clear, then add with saturation.
    always_comb begin
        base = clr ? '0 : cnt_q;
        sum  = SW'(base) + SW'(zeros_in_byte(byte_in));
        if (add_en) begin
            cnt_nxt = (sum > SW'(LIMIT)) ? CW'(SAT) : CW'(sum);
        end else begin
            cnt_nxt = base;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    a_r3_stays_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt_q == CW'(SAT)) |=> (cnt_q == CW'(SAT)));

    a_r2_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en) |=> $stable(cnt_q));

    a_r2_never_decreases: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && add_en) |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/esc_sequencer.sv
// Module: phase and byte-position sequencer.
// Steps through data bytes, check bytes and an optional fill burst. An
// accepted start (go) overrides every phase, including a running burst.
// Assumes ECC_BYTES <= DATA_BYTES and DATA_BYTES >= 2.
module esc_sequencer #(
    parameter int DATA_BYTES = 512,
    parameter int ECC_BYTES  = 13,
    parameter int IW         = $clog2(DATA_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic          in_valid,
    input  logic          need_fill,
    output logic          take_data,
    output logic          take_ecc,
    output logic          last_ecc,
    output logic          out_valid,
    output logic [IW-1:0] out_idx
);
    import esc_pkg::*;

    phase_t        ph_q, ph_n;
    logic [IW-1:0] idx_q, idx_n, base_idx;

    // Byte acceptance decode for the current cycle.
    always_comb begin
        base_idx  = go ? '0 : idx_q;
        take_data = in_valid && (go || ph_q == PH_DATA);
        take_ecc  = in_valid && !go && ph_q == PH_ECC;
        last_ecc  = take_ecc && idx_q == IW'(ECC_BYTES - 1);
    end

    // Next phase and position.
    always_comb begin
        ph_n  = ph_q;
        idx_n = idx_q;
        if (go) begin
            ph_n  = PH_DATA;
            idx_n = '0;
        end
        if (take_data) begin
            if (base_idx == IW'(DATA_BYTES - 1)) begin
                ph_n  = PH_ECC;
                idx_n = '0;
            end else begin
                idx_n = base_idx + 1'b1;
            end
        end else if (take_ecc) begin
            if (last_ecc) begin
                ph_n  = need_fill ? PH_FILL : PH_IDLE;
                idx_n = '0;
            end else begin
                idx_n = idx_q + 1'b1;
            end
        end else if (!go && ph_q == PH_FILL) begin
            if (idx_q == IW'(DATA_BYTES - 1)) begin
                ph_n  = PH_IDLE;
                idx_n = '0;
            end else begin
                idx_n = idx_q + 1'b1;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            idx_q <= '0;
        end else begin
            ph_q  <= ph_n;
            idx_q <= idx_n;
        end
    end

    assign out_valid = (ph_q == PH_FILL);
    assign out_idx   = idx_q;

    a_r7_burst_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(last_ecc));

    a_r7_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !go && out_idx != IW'(DATA_BYTES - 1))
        |=> (out_valid && out_idx == $past(out_idx) + 1'b1));

    a_r8_start_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (go && out_valid) |=> !out_valid);

    a_r2_one_region: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_data && take_ecc));

endmodule

// File: rtl/erased_sector_check.sv
// Module: erased sector zero-bit checker (top).
// Counts zero bits in the data and check regions of a sector that the
// decoder could not repair, then decides erased or uncorrectable and, for
// erased sectors with zero bits in data, drives an all-ones fill burst.
// Assumes the caller streams exactly DATA_BYTES + ECC_BYTES bytes.
module erased_sector_check #(
    parameter int DATA_BYTES = 512,
    parameter int ECC_BYTES  = 13,
    parameter int LIMIT      = 8,
    parameter int ERRW       = 4,
    parameter int CW         = $clog2(LIMIT + 2),
    parameter int IW         = $clog2(DATA_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [ERRW-1:0] err_count,
    input  logic            in_valid,
    input  logic [7:0]      in_byte,
    output logic            done,
    output logic            erased,
    output logic            uncorrectable,
    output logic [CW-1:0]   data_zeros,
    output logic            out_valid,
    output logic [IW-1:0]   out_idx,
    output logic [7:0]      out_byte
);
    localparam int NREG = 2;

    logic            go;
    logic            take_data, take_ecc, last_ecc;
    logic [NREG-1:0] add_vec;
    logic [CW-1:0]   cnt_nxt [NREG];
    logic [CW:0]     total;
    logic            erased_now, need_fill;

    assign go      = start && (err_count > ERRW'(LIMIT));
    assign add_vec = {take_ecc, take_data};

    // One tally per region: index 0 data, index 1 check bytes.
    for (genvar g = 0; g < NREG; g++) begin : g_tally
        esc_zero_tally #(.LIMIT(LIMIT), .CW(CW)) u_tally (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (go),
            .add_en  (add_vec[g]),
            .byte_in (in_byte),
            .cnt_nxt (cnt_nxt[g])
        );
    end

    // Verdict from the counts including the byte accepted this cycle.
    always_comb begin
        total      = {1'b0, cnt_nxt[0]} + {1'b0, cnt_nxt[1]};
        erased_now = (total <= (CW+1)'(LIMIT));
        need_fill  = erased_now && (cnt_nxt[0] != '0);
    end

    esc_sequencer #(
        .DATA_BYTES (DATA_BYTES),
        .ECC_BYTES  (ECC_BYTES),
        .IW         (IW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .in_valid  (in_valid),
        .need_fill (need_fill),
        .take_data (take_data),
        .take_ecc  (take_ecc),
        .last_ecc  (last_ecc),
        .out_valid (out_valid),
        .out_idx   (out_idx)
    );

    // Verdict registers: cleared by start, loaded on the last check byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done          <= 1'b0;
            erased        <= 1'b0;
            uncorrectable <= 1'b0;
            data_zeros    <= '0;
        end else if (go) begin
            done          <= 1'b0;
            erased        <= 1'b0;
            uncorrectable <= 1'b0;
            data_zeros    <= '0;
        end else if (last_ecc) begin
            done          <= 1'b1;
            erased        <= erased_now;
            uncorrectable <= !erased_now;
            data_zeros    <= cnt_nxt[0];
        end else begin
            done          <= 1'b0;
        end
    end

    assign out_byte = out_valid ? 8'hFF : 8'h00;

    a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (erased ^ uncorrectable));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !last_ecc) |=> ($stable(erased) && $stable(uncorrectable) && $stable(data_zeros)));

    a_r7_burst_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && erased && data_zeros != '0) |-> (out_valid && out_idx == '0));

    a_r6_erased_bound: assert property (@(posedge clk) disable iff (!rst_n)
        erased |-> (data_zeros <= CW'(LIMIT)));

    a_r4_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (!done && !erased && !uncorrectable));

endmodule

// File: tb/erased_sector_check_bench.sv
`timescale 1ns/1ps
module erased_sector_check_bench;
    localparam int NDATA = 512;
    localparam int NECC  = 13;
    localparam int NB    = NDATA + NECC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] err_count = 4'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'd0;
    logic       done, erased, uncorrectable, out_valid;
    logic [3:0] data_zeros;
    logic [8:0] out_idx;
    logic [7:0] out_byte;

    int n_chk = 0;
    int n_fail = 0;
    bit seen_done = 0;
    logic [7:0] sec [NB];

    always #4 clk = ~clk;

    erased_sector_check u_erased_sector_check (
        .clk(clk), .rst_n(rst_n), .start(start), .err_count(err_count),
        .in_valid(in_valid), .in_byte(in_byte), .done(done), .erased(erased),
        .uncorrectable(uncorrectable), .data_zeros(data_zeros),
        .out_valid(out_valid), .out_idx(out_idx), .out_byte(out_byte)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int zeros8(input logic [7:0] b);
        int n = 0;
        for (int i = 0; i < 8; i++) if (!b[i]) n++;
        return n;
    endfunction

    // Reference saturating count over sec[lo..hi].
    function automatic int sat_zeros(input int lo, input int hi);
        int acc = 0;
        for (int i = lo; i <= hi; i++) begin
            acc += zeros8(sec[i]);
            if (acc > 8) return 9;
        end
        return acc;
    endfunction

    function automatic void fill_ones();
        for (int i = 0; i < NB; i++) sec[i] = 8'hFF;
    endfunction

    function automatic void drop_bits(input int lo, input int len, input int n);
        for (int k = 0; k < n; k++) begin
            int p;
            p = lo + int'($urandom % len);
            sec[p][$urandom % 8] = 1'b0;
        end
    endfunction

    // Called just after a negedge; returns one negedge later.
    task automatic do_start(input logic [3:0] e, input bit with_byte, input logic [7:0] b);
        start = 1'b1; err_count = e; in_valid = with_byte; in_byte = b;
        @(negedge clk);
        seen_done |= done;
        start = 1'b0; in_valid = 1'b0;
    endtask

    task automatic stream(input int lo, input int hi, input int gap);
        for (int i = lo; i <= hi; i++) begin
            while (int'($urandom % 100) < gap) begin
                in_valid = 1'b0; in_byte = 8'($urandom);
                @(negedge clk);
                seen_done |= done | out_valid;
            end
            in_valid = 1'b1; in_byte = sec[i];
            @(negedge clk);
            seen_done |= done | out_valid;
        end
        in_valid = 1'b0;
    endtask

    // At the negedge after the last check byte was accepted.
    task automatic check_verdict();
        int dz, ez, bad;
        bit er, fl;
        dz = sat_zeros(0, NDATA - 1);
        ez = sat_zeros(NDATA, NB - 1);
        er = (dz + ez) <= 8;
        fl = er && dz != 0;
        chk(done == 1'b1, "R5 done pulse", int'(done), 1);
        chk(erased == er, "R6 erased", int'(erased), int'(er));
        chk(uncorrectable == !er, "R6 uncorrectable", int'(uncorrectable), int'(!er));
        if (dz == 9) chk(data_zeros == 4'd9, "R3 saturated data count", int'(data_zeros), dz);
        else         chk(data_zeros == dz[3:0], "R2 data count", int'(data_zeros), dz);
        if (fl) begin
            bad = 0;
            for (int i = 0; i < NDATA; i++) begin
                if (!(out_valid && out_byte == 8'hFF && out_idx == i[8:0])) bad++;
                if (i == 1 && done) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R7 fill burst mismatches", bad, 0);
            chk(out_valid == 1'b0, "R7 burst end", int'(out_valid), 0);
        end else begin
            chk(out_valid == 1'b0, "R7 no burst", int'(out_valid), 0);
            @(negedge clk);
            chk(done == 1'b0 && out_valid == 1'b0, "R5 single pulse", int'(done), 0);
        end
        chk(erased == er && data_zeros == dz[3:0], "R5 verdict held", int'(erased), int'(er));
    endtask

    task automatic run_full(input int gap);
        do_start(4'd9 + 4'($urandom % 7), 1'b0, 8'h00);
        stream(0, NB - 1, gap);
        check_verdict();
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !erased && !uncorrectable && !out_valid && data_zeros == 0,
            "R5 reset state", int'(done), 0);

        // Clean sector: erased, nothing to fill.
        fill_ones(); run_full(0);
        // 3 data + 2 check zeros: erased with burst.
        fill_ones(); sec[5][0] = 0; sec[300][7] = 0; sec[511][3] = 0;
        sec[512][1] = 0; sec[524][6] = 0; run_full(20);
        // 5 + 4 = 9: uncorrectable.
        fill_ones(); sec[0] = 8'hE0; sec[520] = 8'hF0; run_full(10);
        // Exactly 8 in data, none in check: erased boundary.
        fill_ones(); sec[100] = 8'h0F; sec[200] = 8'hF0; run_full(0);
        // No data zeros, 9 in check: uncorrectable, count 0.
        fill_ones(); sec[512] = 8'h00; sec[513] = 8'hFE; run_full(5);
        // Dense data: saturation.
        for (int i = 0; i < NB; i++) sec[i] = 8'($urandom);
        run_full(30);

        // Random sparse sectors.
        for (int t = 0; t < 8; t++) begin
            fill_ones();
            drop_bits(0, NDATA, int'($urandom % 7));
            drop_bits(NDATA, NECC, int'($urandom % 6));
            run_full(int'($urandom % 40));
        end

        // R1: start with err_count 8 is ignored, stream has no effect.
        fill_ones(); sec[0] = 8'hFE; run_full(0);
        seen_done = 0;
        fill_ones(); sec[3] = 8'h00; sec[600 - 80] = 8'h00;
        do_start(4'd8, 1'b1, sec[0]);
        stream(1, NB - 1, 10);
        repeat (3) begin @(negedge clk); seen_done |= done | out_valid; end
        chk(seen_done == 0, "R1 low error count ignored", int'(seen_done), 0);
        chk(erased == 1'b1 && data_zeros == 4'd1, "R1 verdict untouched", int'(data_zeros), 1);

        // R4: restart mid-stream with a byte in the start cycle.
        fill_ones(); sec[10] = 8'h00; sec[50] = 8'h00;
        do_start(4'd10, 1'b0, 8'h00);
        stream(0, 99, 10);
        fill_ones(); sec[0] = 8'hFE; sec[400][2] = 0; sec[515][5] = 0;
        do_start(4'd12, 1'b1, sec[0]);
        stream(1, NB - 1, 15);
        chk(data_zeros == 4'd2, "R4 first byte counted in start cycle", int'(data_zeros), 2);
        check_verdict();

        // R8: start during a fill burst.
        fill_ones(); sec[7][1] = 0;
        do_start(4'd15, 1'b0, 8'h00);
        stream(0, NB - 1, 0);
        chk(out_valid == 1'b1, "R7 burst began", int'(out_valid), 1);
        repeat (10) @(negedge clk);
        do_start(4'd9, 1'b0, 8'h00);
        chk(out_valid == 1'b0, "R8 burst aborted", int'(out_valid), 0);
        chk(!erased && !done && data_zeros == 0, "R4 start clears verdict", int'(erased), 0);
        fill_ones(); sec[513] = 8'h7F;
        stream(0, NB - 1, 10);
        check_verdict();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule